// File: doc/BRIEF.md
# Mode-Dependent Program Counter and Interrupt Vector Composer

This block keeps the 32-bit address of the instruction being fetched. Each cycle it either holds the address, steps it forward by the length of an instruction, loads an absolute jump target, or adds a signed displacement for a relative branch. The arithmetic depends on an addressing-mode bit. In Native mode, a carry out of bit 15 is thrown away, so the upper half of the address never changes on a step or a relative branch. In Extended mode, the sum carries across all 32 bits.

The same block also builds the 32-bit indirect address that an interrupt acknowledge cycle needs. The address is made from an interrupt base register, a base register for the assigned lines, and the vector that the peripheral supplies. The main interrupt line has two layouts, chosen by the interrupt mode. Three extra lines use fixed per-line codes under a programmable base. Fetching from memory and choosing between interrupts are done elsewhere.

Top module: `pc_vector_unit`

## Requirements
- R1: When `rst` is high at a clock edge, `pc` becomes 0, Native mode is selected, `vec_valid` becomes 0, and both base registers become 0.
- R2: When `pc_op` is 2'b01 (step) in Native mode (mode bit 0), the low 16 bits become (low16 + `inc_len`) mod 2^16 and the upper 16 bits stay the same.
- R3: When `pc_op` is 2'b01 in Extended mode (mode bit 1), `pc` becomes `pc` + `inc_len` mod 2^32, with the carry running into the upper half.
- R4: When `pc_op` is 2'b10 (jump), `pc` takes all 32 bits of `jump_addr`, in either mode.
- R5: When `pc_op` is 2'b11 (relative), the target is `pc` plus the sign-extended 16-bit `rel_disp`. In Native mode only the low 16 bits take the sum, modulo 2^16, and the upper half is kept. In Extended mode the full 32-bit sum is used.
- R6: `mode_wr` loads the mode bit from `mode_ext`. A `pc_op` in the same cycle still uses the old mode.
- R7: When `pc_op` is 2'b00 (hold), `pc` does not change.
- R8: A request with `int_line` = 0 and `int_mode` = 2 gives `vec_valid` = 1 on the next cycle, with `vec_addr` = {interrupt base[23:0], `periph_vec`[7:0]}.
- R9: A request with `int_line` = 0 and `int_mode` = 3 gives `vec_addr` = {interrupt base[23:8], `periph_vec`[15:0]} on the next cycle.
- R10: A request with `int_line` = k (1..3) gives `vec_addr` = {interrupt base[23:8], assigned base[6:0], code_k}, whatever `int_mode` is. The 9-bit codes are 9'h014, 9'h098 and 9'h11C for lines 1, 2 and 3.
- R11: A request on line 0 with `int_mode` 0 or 1, and any cycle without a request, gives `vec_valid` = 0 on the next cycle.
- R12: `ibase_wr` loads the 24-bit interrupt base and `abase_wr` loads the 7-bit assigned base. A vector requested in the same cycle as a write still uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_op | input | 2 | Operation: 00 hold, 01 step, 10 jump, 11 relative |
| inc_len | input | 3 | Step amount in bytes |
| jump_addr | input | 32 | Absolute target for a jump |
| rel_disp | input | 16 | Signed displacement for a relative branch |
| mode_wr | input | 1 | Write enable for the mode bit |
| mode_ext | input | 1 | New mode: 0 Native, 1 Extended |
| ibase_wr | input | 1 | Write enable for the interrupt base |
| ibase_data | input | 24 | New interrupt base (address bits 31:8) |
| abase_wr | input | 1 | Write enable for the assigned base |
| abase_data | input | 7 | New assigned base (address bits 15:9) |
| vec_req | input | 1 | Request to build a vector address |
| int_mode | input | 2 | Interrupt mode for the main line |
| int_line | input | 2 | 0 main line, 1..3 assigned lines |
| periph_vec | input | 16 | Vector supplied by the peripheral |
| pc | output | 32 | Current program counter |
| vec_valid | output | 1 | `vec_addr` holds a new vector this cycle |
| vec_addr | output | 32 | Composed interrupt vector address |

## Verification
The bench places the counter just below a 64K boundary and then steps it and branches across that boundary, both forward and backward. A design that let the carry through in Native mode, or that blocked it in Extended mode, would show the wrong upper half. The mode is changed in the same cycle as a step, and the base registers are written in the same cycle as a vector request, so a design that used the new value too early would give a different address. Vectors are built for every line and every layout, including the lines that share bits 31:16 and the cases of an unsupported mode. A design that mixed up the bit splits, swapped the line codes, or flagged a vector it should not produce would be caught.

// File: rtl/pcv_pkg.sv
package pcv_pkg;

    localparam int ADDR_W  = 32;
    localparam int HALF_W  = 16;
    localparam int IBASE_W = 24;
    localparam int ABASE_W = 7;
    localparam int CODE_W  = 9;
    localparam int PVEC_W  = 16;

    typedef enum logic [1:0] {
        PC_HOLD = 2'b00,
        PC_STEP = 2'b01,
        PC_JUMP = 2'b10,
        PC_REL  = 2'b11
    } pc_op_e;

    typedef enum logic {
        ADDR_NATIVE = 1'b0,
        ADDR_EXT    = 1'b1
    } addr_mode_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } vec_out_t;

    // Add under the mode's carry rule: Native keeps the upper half.
    function automatic logic [ADDR_W-1:0] mode_add(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] delta,
        input addr_mode_e        mode
    );
        logic [ADDR_W-1:0] full;
        full = base + delta;
        if (mode == ADDR_NATIVE)
            return {base[ADDR_W-1:HALF_W], full[HALF_W-1:0]};
        return full;
    endfunction

endpackage

// File: rtl/pcv_ctrl_regs.sv
module pcv_ctrl_regs
    import pcv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_wr,
    input  logic               mode_ext,
    input  logic               ibase_wr,
    input  logic [IBASE_W-1:0] ibase_data,
    input  logic               abase_wr,
    input  logic [ABASE_W-1:0] abase_data,
    output addr_mode_e         mode_q,
    output logic [IBASE_W-1:0] ibase_q,
    output logic [ABASE_W-1:0] abase_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= ADDR_NATIVE;
            ibase_q <= '0;
            abase_q <= '0;
        end else begin
            if (mode_wr)
                mode_q <= mode_ext ? ADDR_EXT : ADDR_NATIVE;
            if (ibase_wr)
                ibase_q <= ibase_data;
            if (abase_wr)
                abase_q <= abase_data;
        end
    end

endmodule

// File: rtl/pcv_pc_unit.sv
module pcv_pc_unit
    import pcv_pkg::*;
#(
    parameter int LEN_W  = 3,
    parameter int DISP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_op_e            op,
    input  addr_mode_e        mode,
    input  logic [LEN_W-1:0]  inc_len,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic [DISP_W-1:0] rel_disp,
    output logic [ADDR_W-1:0] pc_q
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] step_delta;
    logic [ADDR_W-1:0] rel_delta;
    logic [ADDR_W-1:0] pc_d;

    assign step_delta = {{(ADDR_W-LEN_W){1'b0}}, inc_len};
    assign rel_delta  = {{EXT_W{rel_disp[DISP_W-1]}}, rel_disp};

    always_comb begin
        unique case (op)
            PC_HOLD: pc_d = pc_q;
            PC_STEP: pc_d = mode_add(pc_q, step_delta, mode);
            PC_JUMP: pc_d = jump_addr;
            PC_REL:  pc_d = mode_add(pc_q, rel_delta, mode);
            default: pc_d = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= '0;
        else
            pc_q <= pc_d;
    end

endmodule

// File: rtl/pcv_vec_compose.sv
module pcv_vec_compose
    import pcv_pkg::*;
#(
    parameter logic [CODE_W-1:0] LINE1_CODE = 9'h014,
    parameter logic [CODE_W-1:0] LINE2_CODE = 9'h098,
    parameter logic [CODE_W-1:0] LINE3_CODE = 9'h11C
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [1:0]         imode,
    input  logic [1:0]         line,
    input  logic [PVEC_W-1:0]  pvec,
    input  logic [IBASE_W-1:0] ibase,
    input  logic [ABASE_W-1:0] abase,
    output vec_out_t           vec_q
);

    localparam int N_ASSIGNED = 3;
    localparam int LO_W       = ADDR_W - IBASE_W;

    function automatic logic [CODE_W-1:0] line_code(input int idx);
        case (idx)
            1:       return LINE1_CODE;
            2:       return LINE2_CODE;
            default: return LINE3_CODE;
        endcase
    endfunction

    logic [ADDR_W-1:0] assigned_addr [N_ASSIGNED+1];
    logic [ADDR_W-1:0] main_m2;
    logic [ADDR_W-1:0] main_m3;
    vec_out_t          vec_d;

    assign assigned_addr[0] = '0;

    for (genvar g = 1; g <= N_ASSIGNED; g++) begin : g_line
        assign assigned_addr[g] = {ibase[IBASE_W-1:IBASE_W-HALF_W], abase, line_code(g)};
    end

    assign main_m2 = {ibase, pvec[LO_W-1:0]};
    assign main_m3 = {ibase[IBASE_W-1:IBASE_W-HALF_W], pvec};

    always_comb begin
        vec_d = '{valid: 1'b0, addr: vec_q.addr};
        if (req) begin
            if (line != 2'd0) begin
                vec_d = '{valid: 1'b1, addr: assigned_addr[line]};
            end else if (imode == 2'd2) begin
                vec_d = '{valid: 1'b1, addr: main_m2};
            end else if (imode == 2'd3) begin
                vec_d = '{valid: 1'b1, addr: main_m3};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            vec_q <= '0;
        else
            vec_q <= vec_d;
    end

endmodule

// File: rtl/pc_vector_unit.sv
module pc_vector_unit
    import pcv_pkg::*;
#(
    parameter int                LEN_W      = 3,
    parameter int                DISP_W     = 16,
    parameter logic [CODE_W-1:0] LINE1_CODE = 9'h014,
    parameter logic [CODE_W-1:0] LINE2_CODE = 9'h098,
    parameter logic [CODE_W-1:0] LINE3_CODE = 9'h11C
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         pc_op,
    input  logic [LEN_W-1:0]   inc_len,
    input  logic [ADDR_W-1:0]  jump_addr,
    input  logic [DISP_W-1:0]  rel_disp,
    input  logic               mode_wr,
    input  logic               mode_ext,
    input  logic               ibase_wr,
    input  logic [IBASE_W-1:0] ibase_data,
    input  logic               abase_wr,
    input  logic [ABASE_W-1:0] abase_data,
    input  logic               vec_req,
    input  logic [1:0]         int_mode,
    input  logic [1:0]         int_line,
    input  logic [PVEC_W-1:0]  periph_vec,
    output logic [ADDR_W-1:0]  pc,
    output logic               vec_valid,
    output logic [ADDR_W-1:0]  vec_addr
);

    addr_mode_e         mode_q;
    logic [IBASE_W-1:0] ibase_q;
    logic [ABASE_W-1:0] abase_q;
    vec_out_t           vec_q;

    pcv_ctrl_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_ext   (mode_ext),
        .ibase_wr   (ibase_wr),
        .ibase_data (ibase_data),
        .abase_wr   (abase_wr),
        .abase_data (abase_data),
        .mode_q     (mode_q),
        .ibase_q    (ibase_q),
        .abase_q    (abase_q)
    );

    pcv_pc_unit #(
        .LEN_W  (LEN_W),
        .DISP_W (DISP_W)
    ) u_pc (
        .clk       (clk),
        .rst       (rst),
        .op        (pc_op_e'(pc_op)),
        .mode      (mode_q),
        .inc_len   (inc_len),
        .jump_addr (jump_addr),
        .rel_disp  (rel_disp),
        .pc_q      (pc)
    );

    pcv_vec_compose #(
        .LINE1_CODE (LINE1_CODE),
        .LINE2_CODE (LINE2_CODE),
        .LINE3_CODE (LINE3_CODE)
    ) u_vec (
        .clk   (clk),
        .rst   (rst),
        .req   (vec_req),
        .imode (int_mode),
        .line  (int_line),
        .pvec  (periph_vec),
        .ibase (ibase_q),
        .abase (abase_q),
        .vec_q (vec_q)
    );

    assign vec_valid = vec_q.valid;
    assign vec_addr  = vec_q.addr;

endmodule

// File: rtl/pc_vector_unit_chk.sv
module pc_vector_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [1:0]  pc_op,
    input logic [2:0]  inc_len,
    input logic [31:0] jump_addr,
    input logic        mode_bit,
    input logic        vec_req,
    input logic [1:0]  int_mode,
    input logic [1:0]  int_line,
    input logic [15:0] periph_vec,
    input logic [31:0] pc,
    input logic        vec_valid,
    input logic [31:0] vec_addr
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (pc == 32'h0 && !vec_valid && !mode_bit));

    a_r2_native_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (!mode_bit && pc_op == 2'b01) |=> pc[31:16] == $past(pc[31:16]));

    a_r3_ext_full_carry: assert property (@(posedge clk) disable iff (rst)
        (mode_bit && pc_op == 2'b01) |=> pc == $past(pc) + {29'h0, $past(inc_len)});

    a_r4_jump_loads: assert property (@(posedge clk) disable iff (rst)
        (pc_op == 2'b10) |=> pc == $past(jump_addr));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (pc_op == 2'b00) |=> $stable(pc));

    a_r8_mode2_low_byte: assert property (@(posedge clk) disable iff (rst)
        (vec_req && int_line == 2'd0 && int_mode == 2'd2)
            |=> (vec_valid && vec_addr[7:0] == $past(periph_vec[7:0])));

    a_r9_mode3_low_half: assert property (@(posedge clk) disable iff (rst)
        (vec_req && int_line == 2'd0 && int_mode == 2'd3)
            |=> (vec_valid && vec_addr[15:0] == $past(periph_vec)));

    a_r11_no_vector: assert property (@(posedge clk) disable iff (rst)
        (!vec_req || (int_line == 2'd0 && int_mode[1] == 1'b0)) |=> !vec_valid);

endmodule

bind pc_vector_unit pc_vector_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pc_op      (pc_op),
    .inc_len    (inc_len),
    .jump_addr  (jump_addr),
    .mode_bit   (mode_q),
    .vec_req    (vec_req),
    .int_mode   (int_mode),
    .int_line   (int_line),
    .periph_vec (periph_vec),
    .pc         (pc),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr)
);

// File: tb/pc_vector_unit_test.sv
`timescale 1ns/1ps
module pc_vector_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  pc_op;
    logic [2:0]  inc_len;
    logic [31:0] jump_addr;
    logic [15:0] rel_disp;
    logic        mode_wr, mode_ext;
    logic        ibase_wr;
    logic [23:0] ibase_data;
    logic        abase_wr;
    logic [6:0]  abase_data;
    logic        vec_req;
    logic [1:0]  int_mode, int_line;
    logic [15:0] periph_vec;
    logic [31:0] pc;
    logic        vec_valid;
    logic [31:0] vec_addr;

    always #5 clk = ~clk;

    pc_vector_unit uut (
        .clk(clk), .rst(rst), .pc_op(pc_op), .inc_len(inc_len),
        .jump_addr(jump_addr), .rel_disp(rel_disp),
        .mode_wr(mode_wr), .mode_ext(mode_ext),
        .ibase_wr(ibase_wr), .ibase_data(ibase_data),
        .abase_wr(abase_wr), .abase_data(abase_data),
        .vec_req(vec_req), .int_mode(int_mode), .int_line(int_line),
        .periph_vec(periph_vec),
        .pc(pc), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    typedef struct {
        string       tag;
        logic [31:0] pc;
        logic        vv;
        logic [31:0] va;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    // Bench reference state, built from the requirements
    logic [31:0] m_pc;
    logic        m_ext;
    logic [23:0] m_ibase;
    logic [6:0]  m_abase;

    function automatic logic [31:0] ref_add(logic [31:0] a, logic [31:0] d, logic ext);
        logic [31:0] s;
        s = a + d;
        return ext ? s : {a[31:16], s[15:0]};
    endfunction

    function automatic logic [8:0] ref_code(logic [1:0] ln);
        case (ln)
            2'd1:    return 9'h014;
            2'd2:    return 9'h098;
            default: return 9'h11C;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic idle();
        pc_op = 2'b00; inc_len = '0; jump_addr = '0; rel_disp = '0;
        mode_wr = 0; mode_ext = 0; ibase_wr = 0; ibase_data = '0;
        abase_wr = 0; abase_data = '0; vec_req = 0; int_mode = '0;
        int_line = '0; periph_vec = '0;
    endtask

    // Driver: inputs already set; compute expectation, push, advance one cycle
    task automatic tick(string tag);
        exp_t e;
        e.tag = tag;
        case (pc_op)
            2'b01:   e.pc = ref_add(m_pc, {29'h0, inc_len}, m_ext);
            2'b10:   e.pc = jump_addr;
            2'b11:   e.pc = ref_add(m_pc, {{16{rel_disp[15]}}, rel_disp}, m_ext);
            default: e.pc = m_pc;
        endcase
        e.vv = 1'b0;
        e.va = '0;
        if (vec_req) begin
            if (int_line != 2'd0) begin
                e.vv = 1'b1;
                e.va = {m_ibase[23:8], m_abase, ref_code(int_line)};
            end else if (int_mode == 2'd2) begin
                e.vv = 1'b1;
                e.va = {m_ibase, periph_vec[7:0]};
            end else if (int_mode == 2'd3) begin
                e.vv = 1'b1;
                e.va = {m_ibase[23:8], periph_vec};
            end
        end
        q.push_back(e);
        m_pc = e.pc;
        if (mode_wr)  m_ext   = mode_ext;
        if (ibase_wr) m_ibase = ibase_data;
        if (abase_wr) m_abase = abase_data;
        @(negedge clk);
        idle();
    endtask

    // Monitor: pop one expectation per cycle after the edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " pc"}, pc, e.pc);
                check({e.tag, " vec_valid"}, {31'h0, vec_valid}, {31'h0, e.vv});
                if (e.vv)
                    check({e.tag, " vec_addr"}, vec_addr, e.va);
            end
        end
    end

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        idle();
        rst = 1'b1;
        m_pc = '0; m_ext = 0; m_ibase = '0; m_abase = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 pc", pc, 32'h0);
        check("R1 vec_valid", {31'h0, vec_valid}, 32'h0);
        vec_req = 1; int_mode = 2'd2; periph_vec = 16'h00AB;
        tick("R1 base cleared");
        // R1 Native by default, R2 native step wraps low half
        pc_op = 2'b10; jump_addr = 32'h1234_FFFE; tick("R4 jump");
        pc_op = 2'b01; inc_len = 3'd3; tick("R2 native step wrap");
        pc_op = 2'b00; tick("R7 hold");
        pc_op = 2'b01; inc_len = 3'd7; tick("R2 native step");
        // R6: mode write with step in same cycle uses old mode
        pc_op = 2'b10; jump_addr = 32'h1234_FFFE; tick("R4 jump again");
        pc_op = 2'b01; inc_len = 3'd3; mode_wr = 1; mode_ext = 1; tick("R6 old mode");
        pc_op = 2'b10; jump_addr = 32'h1234_FFFE; tick("R4 jump ext");
        pc_op = 2'b01; inc_len = 3'd3; tick("R3 ext carry");
        pc_op = 2'b11; rel_disp = 16'hFFFE; tick("R5 ext rel back");
        pc_op = 2'b11; rel_disp = 16'h0004; tick("R5 ext rel fwd");
        mode_wr = 1; mode_ext = 0; tick("R6 to native");
        pc_op = 2'b11; rel_disp = 16'h0010; tick("R5 native rel wrap");
        pc_op = 2'b11; rel_disp = 16'hFFE0; tick("R5 native rel back wrap");
        pc_op = 2'b10; jump_addr = 32'hDEAD_BEEF; tick("R4 native jump full");
        pc_op = 2'b00; tick("R7 hold native");
        // R12 / R8 / R9
        ibase_wr = 1; ibase_data = 24'hA5C3E1;
        vec_req = 1; int_mode = 2'd2; periph_vec = 16'h337F; tick("R12 ibase old");
        vec_req = 1; int_mode = 2'd2; periph_vec = 16'h337F; tick("R8 mode2");
        vec_req = 1; int_mode = 2'd3; periph_vec = 16'h1234; tick("R9 mode3");
        // R10 / R12 assigned lines
        abase_wr = 1; abase_data = 7'h55;
        vec_req = 1; int_line = 2'd1; tick("R12 abase old");
        vec_req = 1; int_line = 2'd1; int_mode = 2'd0; tick("R10 line1");
        vec_req = 1; int_line = 2'd2; int_mode = 2'd3; tick("R10 line2");
        vec_req = 1; int_line = 2'd3; int_mode = 2'd1; tick("R10 line3");
        // R11 no vector
        vec_req = 1; int_line = 2'd0; int_mode = 2'd0; tick("R11 mode0");
        vec_req = 1; int_line = 2'd0; int_mode = 2'd1; tick("R11 mode1");
        int_line = 2'd2; int_mode = 2'd2; tick("R11 no req");
        // R3 wide ext step sequence
        mode_wr = 1; mode_ext = 1; tick("R6 to ext");
        pc_op = 2'b10; jump_addr = 32'hFFFF_FFFC; tick("R4 near top");
        pc_op = 2'b01; inc_len = 3'd5; tick("R3 ext wrap 32");
        tick("R7 drain");
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule